// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block turns single accesses from a 16-bit processor core into cycles on an external memory bus. The bus carries a 20-bit address and shares its address and data wires. The core raises `req` with an address, write data, byte enables, a write flag and a fetch flag. It holds them until `ack` pulses for one clock. The block then runs a fixed four-phase cycle on the pins.

1. In the address phase, the address strobe `addr_stb` is high and the shared lines carry address bits.
2. In the hold phase, the strobe is low and the address stays on the lines.
3. In the strobe phase, the shared lines carry write data, or they are released so memory can drive read data.
4. In the recovery phase, the cycle finishes.

The external data path is 8 or 16 bits wide. The `width_strap` input sets the width while reset is asserted. The value present when reset is released stays in force until the next reset.

In 16-bit mode, one external cycle moves both bytes, and the lowest dedicated address pin serves as the high-byte write strobe. In 8-bit mode, an access that enables both bytes runs as two byte cycles, low byte first. When the bus is idle, the address strobe does not pulse.

Top module: `mux_ext_bus`

## Requirements
- R1: The bus width is the value of `width_strap` on the last clock edge before reset is released (0 = 8-bit, 1 = 16-bit). Changing the strap after release has no effect on any later cycle.
- R2: An accepted request runs address, hold, strobe and recovery phases, one clock each. `addr_stb` is high only in the address phase, and `ack` is high only in the recovery phase of the final byte cycle.
- R3: `a_low[3:1]` carries address bits 3..1 for the whole cycle. During the address and hold phases, `ad_lo_o` carries address bits 11..4 with `ad_lo_oe` high.
- R4: In 16-bit mode, `ad_hi_o` carries address bits 19..12 during the address and hold phases and write data bits 15..8 during a write strobe. In 8-bit mode, it carries address bits 19..12 with `ad_hi_oe` high for the whole cycle.
- R5: In 16-bit mode, `a_low[0]` is the active-low high-byte write strobe, low only in the strobe phase of a write with `be[1]` set. `wr_lo_stb_n` is low only for a write with `be[0]` set. In 8-bit mode, `a_low[0]` is address bit 0 and `wr_lo_stb_n` strobes every written byte.
- R6: `rd_stb_n` goes low for a data read and `fetch_stb_n` goes low for a fetch (the write flag is ignored on a fetch). Each goes low only in the strobe phase. Every strobe is high in all other phases.
- R7: `addr_stb` stays low while no request is in progress, including the cycle after `ack`.
- R8: In 8-bit mode, `be` = 2'b11 runs two byte cycles at the even address and then the odd address, with `ack` after the second. `be` = 2'b01 or 2'b10 runs one cycle with address bit 0 equal to `be[1]`.
- R9: Read data is captured on the clock edge that ends the strobe phase and is valid from `ack` onward. In 16-bit mode, `rdata` = {`ad_hi_i`, `ad_lo_i`}. In 8-bit mode, each byte lands in the lane of its address bit 0, and lanes that are not accessed read 0.
- R10: During a read or fetch strobe, `ad_lo_oe` is low. During a write strobe, `ad_lo_oe` is high and `ad_lo_o` carries the write byte: `wdata[7:0]` in 16-bit mode, or in 8-bit mode the byte selected by address bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| width_strap | input | 1 | Bus width strap, sampled while in reset |
| req | input | 1 | Access request, held until ack |
| we | input | 1 | 1 = write, 0 = read |
| fetch | input | 1 | 1 = program fetch |
| addr | input | 20 | Byte address |
| wdata | input | 16 | Write data |
| be | input | 2 | Byte enables (bit 0 = low byte) |
| ack | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Read data |
| addr_stb | output | 1 | Address latch strobe, active high |
| rd_stb_n | output | 1 | Data read strobe |
| fetch_stb_n | output | 1 | Program fetch strobe |
| wr_lo_stb_n | output | 1 | Low-byte write strobe |
| a_low | output | 4 | Address bits 3..1 plus bit 0 or high-byte write strobe |
| ad_lo_o | output | 8 | Shared low lines, driven value |
| ad_lo_i | input | 8 | Shared low lines, sampled value |
| ad_lo_oe | output | 1 | Drive enable for shared low lines |
| ad_hi_o | output | 8 | Shared high lines, driven value |
| ad_hi_i | input | 8 | Shared high lines, sampled value |
| ad_hi_oe | output | 1 | Drive enable for shared high lines |

## Verification
The assertions cover the rules that hold on every cycle:
- the address strobe is a single-clock pulse followed by a quiet hold phase;
- only one kind of strobe is active at a time, and each lasts one clock;
- the shared low lines are released whenever a read or fetch strobe is low;
- `ack` always follows a strobe phase and is never followed by an address strobe.

The bench scenarios show what a property cannot:
- the bit mapping of address and data onto the pins in each width;
- the byte order and lane placement of split 8-bit accesses;
- the captured read values from an external memory model;
- that a strap change after reset leaves the width unchanged.

// File: rtl/mux_ext_bus.sv
module mux_ext_bus #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          width_strap,
  input  logic          req,
  input  logic          we,
  input  logic          fetch,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW/8-1:0] be,
  output logic          ack,
  output logic [DW-1:0] rdata,
  output logic          addr_stb,
  output logic          rd_stb_n,
  output logic          fetch_stb_n,
  output logic          wr_lo_stb_n,
  output logic [3:0]    a_low,
  output logic [7:0]    ad_lo_o,
  input  logic [7:0]    ad_lo_i,
  output logic          ad_lo_oe,
  output logic [7:0]    ad_hi_o,
  input  logic [7:0]    ad_hi_i,
  output logic          ad_hi_oe
);
  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_HOLD, S_STRB, S_RECV} ph_t;

  ph_t             ph;
  logic            wide_q;
  logic            idx;
  logic [AW-1:1]   a_q;
  logic [DW-1:0]   wd_q;
  logic [DW/8-1:0] be_q;
  logic            we_q, fe_q;

  logic [AW-1:0] cur_a;
  logic          more, in_addr, strb, wr_lo, wr_hi;
  logic [7:0]    wbyte;

  assign cur_a   = {a_q, wide_q ? 1'b0 : idx};
  assign more    = !wide_q && (be_q == 2'b11) && !idx;
  assign in_addr = (ph == S_ADDR) || (ph == S_HOLD);
  assign strb    = (ph == S_STRB);
  assign wr_lo   = strb && we_q && (!wide_q || be_q[0]);
  assign wr_hi   = strb && we_q && wide_q && be_q[1];
  assign wbyte   = (!wide_q && idx) ? wd_q[15:8] : wd_q[7:0];

  assign addr_stb    = (ph == S_ADDR);
  assign ack         = (ph == S_RECV) && !more;
  assign rd_stb_n    = !(strb && !we_q && !fe_q);
  assign fetch_stb_n = !(strb && fe_q);
  assign wr_lo_stb_n = !wr_lo;
  assign a_low       = {cur_a[3:1], wide_q ? !wr_hi : cur_a[0]};
  assign ad_lo_oe    = in_addr || (strb && we_q);
  assign ad_lo_o     = in_addr ? cur_a[11:4] : wbyte;
  assign ad_hi_oe    = wide_q ? ad_lo_oe : (ph != S_IDLE);
  assign ad_hi_o     = (wide_q && !in_addr) ? wd_q[15:8] : cur_a[19:12];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wide_q <= width_strap;
      ph     <= S_IDLE;
      idx    <= 1'b0;
      a_q    <= '0;
      wd_q   <= '0;
      be_q   <= '0;
      we_q   <= 1'b0;
      fe_q   <= 1'b0;
      rdata  <= '0;
    end else begin
      case (ph)
        S_IDLE: if (req) begin
          a_q   <= addr[AW-1:1];
          wd_q  <= wdata;
          be_q  <= be;
          we_q  <= we && !fetch;
          fe_q  <= fetch;
          idx   <= !wide_q && (be == 2'b10);
          rdata <= '0;
          ph    <= S_ADDR;
        end
        S_ADDR: ph <= S_HOLD;
        S_HOLD: ph <= S_STRB;
        S_STRB: begin
          if (!we_q) begin
            if (wide_q)   rdata       <= {ad_hi_i, ad_lo_i};
            else if (idx) rdata[15:8] <= ad_lo_i;
            else          rdata[7:0]  <= ad_lo_i;
          end
          ph <= S_RECV;
        end
        S_RECV: begin
          if (more) begin
            idx <= 1'b1;
            ph  <= S_ADDR;
          end else begin
            ph  <= S_IDLE;
          end
        end
        default: ph <= S_IDLE;
      endcase
    end
  end
endmodule

module mux_ext_bus_chk (
  input logic clk,
  input logic rst_n,
  input logic wide,
  input logic ale,
  input logic rd_n,
  input logic fe_n,
  input logic wl_n,
  input logic a0,
  input logic lo_oe,
  input logic ack
);
  p_ale_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);
  p_hold_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> (rd_n && fe_n && wl_n && (!wide || a0)));
  p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!rd_n, !fe_n, (!wl_n || (wide && !a0))}));
  p_strobe_short_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !fe_n || !wl_n) |=> (rd_n && fe_n && wl_n));
  p_read_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !fe_n) |-> !lo_oe);
  p_ack_after_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(!rd_n || !fe_n || !wl_n || (wide && !a0)));
  p_idle_after_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ale);
endmodule

bind mux_ext_bus mux_ext_bus_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wide(wide_q), .ale(addr_stb),
  .rd_n(rd_stb_n), .fe_n(fetch_stb_n), .wl_n(wr_lo_stb_n),
  .a0(a_low[0]), .lo_oe(ad_lo_oe), .ack(ack)
);

// File: tb/sim_mux_ext_bus.sv
`timescale 1ns/1ps
module sim_mux_ext_bus;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic width_strap = 1'b0;
  logic req = 1'b0, we = 1'b0, fetch = 1'b0;
  logic [19:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [1:0]  be = 2'b11;
  logic ack, addr_stb, rd_stb_n, fetch_stb_n, wr_lo_stb_n, ad_lo_oe, ad_hi_oe;
  logic [15:0] rdata;
  logic [3:0]  a_low;
  logic [7:0]  ad_lo_o, ad_hi_o, ad_lo_i, ad_hi_i;

  int vectors = 0;
  int fails = 0;
  logic done = 1'b0;
  logic wide_b = 1'b0;
  logic [19:0] ba = '0;

  always #4 clk = ~clk;

  mux_ext_bus u0 (
    .clk(clk), .rst_n(rst_n), .width_strap(width_strap), .req(req), .we(we),
    .fetch(fetch), .addr(addr), .wdata(wdata), .be(be), .ack(ack), .rdata(rdata),
    .addr_stb(addr_stb), .rd_stb_n(rd_stb_n), .fetch_stb_n(fetch_stb_n),
    .wr_lo_stb_n(wr_lo_stb_n), .a_low(a_low), .ad_lo_o(ad_lo_o), .ad_lo_i(ad_lo_i),
    .ad_lo_oe(ad_lo_oe), .ad_hi_o(ad_hi_o), .ad_hi_i(ad_hi_i), .ad_hi_oe(ad_hi_oe)
  );

  function automatic logic [7:0] mem(input logic [19:0] a);
    return (a[7:0] * 8'd3) ^ a[15:8] ^ {a[19:16], 4'hA};
  endfunction

  always @(negedge clk)
    if (addr_stb) ba <= {ad_hi_o, ad_lo_o, a_low[3:1], wide_b ? 1'b0 : a_low[0]};
  assign ad_lo_i = mem(ba);
  assign ad_hi_i = mem({ba[19:1], 1'b1});

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic strobes_high(input string tag);
    chk(tag, 32'({rd_stb_n, fetch_stb_n, wr_lo_stb_n, wide_b ? a_low[0] : 1'b1}), 32'hF);
  endtask

  task automatic do_reset(input logic w);
    rst_n = 1'b0; width_strap = w; req = 1'b0; wide_b = w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    width_strap = !w;
    chk("R7 reset strobe idle", 32'({addr_stb, ack, ad_lo_oe, ad_hi_oe}), 32'h0);
    strobes_high("R6 reset strobes high");
  endtask

  task automatic acc(input logic w, input logic f, input logic [19:0] a,
                     input logic [1:0] b, input logic [15:0] d);
    int n;
    logic wr;
    logic [19:0] ea;
    logic [15:0] er;
    logic [7:0] ev, od;
    wr = w && !f;
    n  = (!wide_b && b == 2'b11) ? 2 : 1;
    ev = mem({a[19:1], 1'b0});
    od = mem({a[19:1], 1'b1});
    if (wide_b || b == 2'b11) er = {od, ev};
    else if (b == 2'b01)      er = {8'h00, ev};
    else                      er = {od, 8'h00};
    req = 1'b1; we = w; fetch = f; addr = a; be = b; wdata = d;
    @(negedge clk);
    for (int k = 0; k < n; k++) begin
      if (wide_b) ea = {a[19:1], 1'b0};
      else        ea = {a[19:1], (n == 2) ? k[0] : b[1]};
      chk("R2 address phase strobe", 32'(addr_stb), 32'h1);
      chk("R3 low address pins", 32'(a_low), 32'({ea[3:1], wide_b ? 1'b1 : ea[0]}));
      chk("R3 shared low address", 32'({ad_lo_oe, ad_lo_o}), 32'({1'b1, ea[11:4]}));
      chk("R4 shared high address", 32'({ad_hi_oe, ad_hi_o}), 32'({1'b1, ea[19:12]}));
      chk("R8 byte order address bit", 32'(ea[0]), 32'((n == 2) ? k : (wide_b ? 0 : b[1])));
      strobes_high("R6 strobes high in address phase");
      @(negedge clk);
      chk("R2 hold phase strobe low", 32'(addr_stb), 32'h0);
      chk("R3 address held", 32'({ad_lo_oe, ad_lo_o}), 32'({1'b1, ea[11:4]}));
      strobes_high("R6 strobes high in hold");
      @(negedge clk);
      chk("R6 read and fetch strobes", 32'({rd_stb_n, fetch_stb_n}), 32'({!(!wr && !f), !f}));
      chk("R5 low write strobe", 32'(wr_lo_stb_n), 32'(!(wr && (!wide_b || b[0]))));
      if (wide_b) chk("R5 high write strobe on a0", 32'(a_low[0]), 32'(!(wr && b[1])));
      if (wr) begin
        chk("R10 write byte driven", 32'({ad_lo_oe, ad_lo_o}),
            32'({1'b1, (!wide_b && ea[0]) ? d[15:8] : d[7:0]}));
        if (wide_b) chk("R4 high write data", 32'({ad_hi_oe, ad_hi_o}), 32'({1'b1, d[15:8]}));
      end else begin
        chk("R10 lines released on read", 32'(ad_lo_oe), 32'h0);
      end
      if (!wide_b) chk("R4 narrow high address kept", 32'({ad_hi_oe, ad_hi_o}), 32'({1'b1, ea[19:12]}));
      @(negedge clk);
      strobes_high("R6 strobes high in recovery");
      chk("R1 R8 ack on final byte cycle", 32'({ack, addr_stb}), 32'({k == n - 1, 1'b0}));
      if (k == n - 1) req = 1'b0;
      @(negedge clk);
    end
    chk("R7 no strobe after ack", 32'({addr_stb, ack}), 32'h0);
    if (!wr) chk("R9 read data", 32'(rdata), 32'(er));
    @(negedge clk);
    chk("R7 idle stays quiet", 32'(addr_stb), 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < 2; w++) begin
      do_reset(w[0]);
      for (int t = 0; t < 3; t++)
        for (int b = 1; b < 4; b++)
          for (int i = 0; i < 4; i++) begin
            logic [19:0] a;
            logic [15:0] d;
            a = 20'(32'h2F3A5 * (i + 1) + 32'(t * 7 + b));
            d = 16'(32'hA5C3 ^ (i * 32'h1111) ^ (b << 4));
            acc(t == 1, t == 2, a, b[1:0], d);
          end
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule